// File: doc/BRIEF.md
# Lock-step wide-word issue stage

This block is the issue stage of a statically scheduled wide-word core. Each cycle it may take one 120-bit bundle from fetch. A bundle holds five fixed 24-bit operation fields: one integer field (which may carry a branch), two floating-point fields and two memory fields. The accepted bundle sits in a single issue register. Each field drives its own functional-unit port. A unit strobe fires only for a field that holds an operation, so a bundle may be partly or wholly empty.

The hardware performs no dependence or hazard checks. The scheduler that built the bundle guarantees that the operations are independent. All units advance together. A stall from any one unit, or from the blocking data cache, freezes the whole stage. The held bundle then stays put and no strobe fires.

The fetch side uses valid/ready handshaking with these rules for back-pressure:
- `in_ready` is low exactly while the global stall is present.
- A bundle is consumed only on a cycle where both `in_valid` and `in_ready` are high.
- Fetch must hold an offered bundle stable until it is consumed.

A branch in the integer field raises a one-cycle redirect carrying the target. There is no delay slot, so a bundle consumed in that same cycle is discarded.

Top module: `vliw_lockstep_issue`

## Requirements
- R1: Field k of a bundle occupies bits [24k+23:24k]. Field 0 is integer, fields 1 and 2 are floating-point, and fields 3 and 4 are memory. `slot_op` presents the held bundle with the same bit positions.
- R2: The global stall is the OR of all `unit_stall` bits and `cache_stall`. `in_ready` equals its inverse in the same cycle.
- R3: A bundle consumed at a clock edge (`in_valid` and `in_ready` high, no redirect) appears on `slot_op` after that edge. If `in_ready` is high and `in_valid` is low, the held bundle becomes all zero.
- R4: `slot_fire[k]` is high exactly when held field k is non-zero and no global stall is present. An all-zero field is a NOP.
- R5: While the global stall is high, `slot_op` does not change and every strobe is low. A stall from the cache or from any single unit freezes all five fields, not only its own.
- R6: No dependence checking: fields with identical or overlapping contents all fire together in the same cycle.
- R7: A held integer field whose bits [23:18] equal 6'h3F is a branch. When no stall is present, it raises `redir_valid` for one cycle with `redir_target` equal to bits [17:0] of that field. Under a stall the redirect waits until the stall clears.
- R8: A bundle consumed in a cycle with `redir_valid` high is squashed. The held bundle becomes all zero instead.
- R9: Synchronous reset clears the held bundle to all zero. This leaves every strobe and `redir_valid` low.
- R10: An all-zero bundle fires no strobe. A partly empty bundle fires only its non-zero fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Fetch offers a bundle |
| in_ready | output | 1 | Stage can consume a bundle this cycle |
| in_bundle | input | 120 | Offered bundle, five 24-bit fields |
| unit_stall | input | 5 | Per-unit stall requests |
| cache_stall | input | 1 | Blocking data-cache miss |
| slot_op | output | 120 | Held bundle, one field per unit port |
| slot_fire | output | 5 | Per-unit issue strobe |
| redir_valid | output | 1 | Branch redirect request to fetch |
| redir_target | output | 18 | Branch target |

## Verification
Assertions check four properties on every cycle:
- the held bundle stays stable across a stall, and no strobe fires under it;
- the redirect never lasts two cycles;
- a bundle that meets a redirect is squashed;
- a consumed bundle lands in the issue register.

The bench scenarios show the behaviours that depend on the data and on the order of events: which fields fire for a partly empty bundle, firing of identical fields without any dependence check, that a stall from any single source freezes all five fields, a branch that is delayed by a stall, and a bundle that fetch holds back until `in_ready` returns.

// File: rtl/vliw_issue_pkg.sv
package vliw_issue_pkg;
  localparam int SLOT_W   = 24;
  localparam int NSLOT    = 5;
  localparam int OPC_W    = 6;
  localparam int TGT_W    = SLOT_W - OPC_W;
  localparam int BUNDLE_W = SLOT_W * NSLOT;
  localparam logic [OPC_W-1:0] BRANCH_OPC = '1;
  localparam int SLOT_INT = 0;
endpackage

// File: rtl/vliw_stall_merge.sv
module vliw_stall_merge #(
  parameter int NUNIT = 5
) (
  input  logic [NUNIT-1:0] unit_stall,
  input  logic             cache_stall,
  output logic             stall_any
);
  assign stall_any = (|unit_stall) | cache_stall;
endmodule

// File: rtl/vliw_bundle_reg.sv
module vliw_bundle_reg #(
  parameter int BW = 120
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          advance,
  input  logic          squash,
  input  logic          in_valid,
  input  logic [BW-1:0] in_bundle,
  output logic [BW-1:0] held
);
  always_ff @(posedge clk) begin
    if (rst)
      held <= '0;
    else if (advance)
      held <= (squash || !in_valid) ? '0 : in_bundle;
  end

  // R3
  accept_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && in_valid && !squash) |=> (held == $past(in_bundle)));
endmodule

// File: rtl/vliw_slot_issue.sv
module vliw_slot_issue #(
  parameter int W = 24
) (
  input  logic [W-1:0] field,
  input  logic         stall,
  output logic         fire
);
  assign fire = (field != '0) && !stall;
endmodule

// File: rtl/vliw_lockstep_issue.sv
module vliw_lockstep_issue
  import vliw_issue_pkg::*;
#(
  parameter int SW  = SLOT_W,
  parameter int NS  = NSLOT,
  parameter int OW  = OPC_W,
  parameter int BWD = SW * NS,
  parameter int TW  = SW - OW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [BWD-1:0] in_bundle,
  input  logic [NS-1:0] unit_stall,
  input  logic          cache_stall,
  output logic [BWD-1:0] slot_op,
  output logic [NS-1:0] slot_fire,
  output logic          redir_valid,
  output logic [TW-1:0] redir_target
);
  logic stall;
  logic [BWD-1:0] held;
  logic [SW-1:0] int_field;
  logic is_branch;

  vliw_stall_merge #(.NUNIT(NS)) u_stall (
    .unit_stall(unit_stall), .cache_stall(cache_stall), .stall_any(stall));

  vliw_bundle_reg #(.BW(BWD)) u_hold (
    .clk(clk), .rst(rst), .advance(!stall), .squash(redir_valid),
    .in_valid(in_valid), .in_bundle(in_bundle), .held(held));

  for (genvar k = 0; k < NS; k++) begin : g_slot
    vliw_slot_issue #(.W(SW)) u_slot (
      .field(held[k*SW +: SW]), .stall(stall), .fire(slot_fire[k]));
  end

  assign int_field    = held[SLOT_INT*SW +: SW];
  assign is_branch    = (int_field[SW-1 -: OW] == OW'(BRANCH_OPC));
  assign redir_valid  = is_branch && !stall;
  assign redir_target = int_field[TW-1:0];
  assign slot_op      = held;
  assign in_ready     = !stall;

  // R5
  frozen_op_chk: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> $stable(slot_op));
  // R4
  no_fire_stalled_chk: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (slot_fire == '0));
  // R7
  redir_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    redir_valid |=> !redir_valid);
  // R8
  squash_chk: assert property (@(posedge clk) disable iff (rst)
    (redir_valid && in_valid) |=> (slot_op == '0));
endmodule

// File: tb/test_vliw_lockstep_issue.sv
module test_vliw_lockstep_issue;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 24;
  localparam int NS = 5;
  localparam int BW = SW * NS;

  logic clk = 0, rst = 1, in_valid = 0, cache_stall = 0;
  logic [BW-1:0] in_bundle = '0;
  logic [NS-1:0] unit_stall = '0;
  logic in_ready, redir_valid;
  logic [BW-1:0] slot_op;
  logic [NS-1:0] slot_fire;
  logic [17:0] redir_target;
  int checks = 0, errors = 0;
  logic [BW-1:0] exp_hold;

  always #(CLK_PERIOD/2) clk = ~clk;

  vliw_lockstep_issue i_vliw_lockstep_issue (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bundle(in_bundle), .unit_stall(unit_stall), .cache_stall(cache_stall),
    .slot_op(slot_op), .slot_fire(slot_fire), .redir_valid(redir_valid),
    .redir_target(redir_target));

  function automatic logic m_stall();
    return (unit_stall != 0) || cache_stall;
  endfunction
  function automatic logic m_redir();
    return (exp_hold[23:18] == 6'h3F) && !m_stall();
  endfunction

  always @(posedge clk) begin
    if (rst) exp_hold <= '0;
    else if (!m_stall()) exp_hold <= (m_redir() || !in_valid) ? '0 : in_bundle;
  end

  task automatic cmp(string tag, string what, logic [BW-1:0] act, logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic v, logic [BW-1:0] b, logic [NS-1:0] us, logic cs,
                      logic r = 0);
    logic [NS-1:0] ef;
    @(negedge clk);
    rst = r; in_valid = v; in_bundle = b; unit_stall = us; cache_stall = cs;
    #1;
    for (int k = 0; k < NS; k++) ef[k] = (exp_hold[k*SW +: SW] != 0) && !m_stall();
    cmp(tag, "slot_op", slot_op, exp_hold);
    cmp(tag, "slot_fire", BW'(slot_fire), BW'(ef));
    cmp(tag, "in_ready", BW'(in_ready), BW'(!m_stall()));
    cmp(tag, "redir_valid", BW'(redir_valid), BW'(m_redir()));
    if (m_redir()) cmp(tag, "redir_target", BW'(redir_target), BW'(exp_hold[17:0]));
  endtask

  function automatic logic [BW-1:0] mk(logic [SW-1:0] m1, m0, f1, f0, i0);
    return {m1, m0, f1, f0, i0};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [BW-1:0] full, br;
    full = mk(24'h0A0001, 24'h0A0002, 24'h050003, 24'h050004, 24'h010005);
    br   = mk('0, '0, '0, '0, 24'hFC1234);
    repeat (2) @(posedge clk);
    step("R9", 1, full, '0, 0, 1);
    step("R9", 0, '0, '0, 0, 0);
    step("R3", 1, full, '0, 0);
    step("R1", 0, '0, '0, 0);
    step("R10", 1, mk('0, 24'h0A0009, '0, 24'h050001, '0), '0, 0);
    step("R10", 1, '0, '0, 0);
    step("R3", 0, full, '0, 0);
    step("R6", 1, {NS{24'h123456}}, '0, 0);
    step("R6", 1, full, '0, 0);
    for (int k = 0; k < NS; k++) step("R5", 1, br, 5'(1 << k), 0);
    step("R5", 1, br, '0, 1);
    step("R2", 1, br, '0, 1);
    step("R2", 1, br, '0, 0);
    step("R7", 1, full, '0, 1);
    step("R7", 1, full, '0, 0);
    step("R8", 1, full, '0, 0);
    step("R8", 0, '0, '0, 0);
    step("R9", 1, full, '0, 0, 1);
    step("R9", 0, '0, '0, 0);
    for (int n = 0; n < 300; n++) begin
      logic [BW-1:0] rb;
      for (int k = 0; k < NS; k++) begin
        logic [SW-1:0] f;
        f = SW'($urandom);
        if ($urandom_range(3) == 0) f = '0;
        if (k == 0 && $urandom_range(4) == 0) f[23:18] = 6'h3F;
        rb[k*SW +: SW] = f;
      end
      step("R4", 1'($urandom), rb, ($urandom_range(4) == 0) ? 5'($urandom) : '0,
           $urandom_range(5) == 0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule